// File: doc/BRIEF.md
# Segment Descriptor Fetch Unit

This block turns a 16-bit segment selector into a cached segment description. On a load request it picks one of two descriptor tables from a selector bit, checks that the whole 8-byte entry lies inside that table's limit, and reads the entry as two 32-bit words through a synchronous memory read port. It then builds the cached base, the limit and the flags word. The limit is widened for page granularity when the descriptor asks for it.

The unit also checks that the descriptor may be loaded into a data segment register. If it may not, or if the entry lies outside the table, the unit reports a fault together with an error code built from the selector. A null selector loads an empty description and makes no memory access. The unit handles one load at a time. A `busy` level covers each load, and a one-cycle `done` pulse ends it.

Top module: `segDescFetch`

## Requirements
- R1: Selector bit 2 set selects the table given by `ldtBase`/`ldtLimit`, and bit 2 clear selects `gdtBase`/`gdtLimit`. The entry offset is the selector with bits 2:0 cleared. The first word is read at table base plus offset and the second at that address plus 4, with read enables in two consecutive cycles.
- R2: If offset + 7 is greater than the selected table limit, the load ends with `fault` high and `faultCode` equal to the selector with bits 1:0 cleared, and no memory read is issued.
- R3: `segBase` is {word1[31:24], word1[7:0], word0[31:16]}.
- R4: The raw limit is {word1[19:16], word0[15:0]}. When word1 bit 23 is set, `segLimit` is the raw limit shifted left by 12 with bits 11:0 set to ones. Otherwise `segLimit` is the raw limit with its upper bits zero.
- R5: A selector whose bits 15:2 are all zero is null. It ends without a fault, with `segBase`, `segLimit` and `segFlags` all zero and no memory read.
- R6: The load faults, with the same error code as in R2, when word1 bit 12 (descriptor class) is clear, or when word1 bit 11 (executable) is set and word1 bit 9 (readable) is clear.
- R7: On a load without a fault, `segFlags` equals the whole word1.
- R8: `done` is a one-cycle pulse. `fault` is high only together with `done`. Counting from the clock edge that accepts a request, `done` is visible after edge 1 for null and range-fault loads and after edge 3 for fetched loads.
- R9: `busy` is high from the cycle after the accepting edge until `done` rises. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request, accepted when not busy |
| selector | input | 16 | Segment selector to load |
| gdtBase | input | ADDR_W | Global table base address |
| gdtLimit | input | ADDR_W | Global table byte limit |
| ldtBase | input | ADDR_W | Local table base address |
| ldtLimit | input | ADDR_W | Local table byte limit |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | ADDR_W | Memory read byte address |
| memRdData | input | 32 | Read data, valid the cycle after the strobe |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Load finished (one-cycle pulse) |
| fault | output | 1 | Load failed, valid with done |
| faultCode | output | 16 | Error code of the last failed load |
| segBase | output | 32 | Cached segment base |
| segLimit | output | 32 | Cached segment limit |
| segFlags | output | 32 | Cached descriptor flags word |

## Verification
The assertions check on every cycle that reads happen only while busy, that the second read address is 4 above the first, that `done` is a single-cycle pulse carrying any fault, and that every completed load agrees with its granularity flag and its null or valid class. Field placement, table selection, the exact range boundary and the latencies depend on the descriptor contents and on the selector. Only the bench sweep shows them: it goes through every entry index up to past the limit of both tables, with descriptors that vary granularity, class and readability. A request held across a busy load shows whether requests are ignored while busy.

// File: rtl/segfetch_pkg.sv
package segfetch_pkg;

  localparam int DESC_W    = 32;
  localparam int SEL_W     = 16;
  localparam int BIT_GRAN  = 23;
  localparam int BIT_CLASS = 12;
  localparam int BIT_EXEC  = 11;
  localparam int BIT_READ  = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD0,
    ST_RD1
  } fetchState_t;

  typedef struct packed {
    logic capture;
    logic readLow;
    logic readHigh;
    logic holdLow;
    logic finNull;
    logic finRange;
    logic finDesc;
  } pathCtrl_t;

endpackage

// File: rtl/segFetchCtrl.sv
module segFetchCtrl
  import segfetch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      isNull,
  input  logic      rangeBad,
  output pathCtrl_t ctl,
  output logic      busy,
  output logic      memRdEn,
  output logic      done
);

  fetchState_t stateQ, stateD;

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          stateD      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (isNull) begin
          ctl.finNull = 1'b1;
          stateD      = ST_IDLE;
        end else if (rangeBad) begin
          ctl.finRange = 1'b1;
          stateD       = ST_IDLE;
        end else begin
          ctl.readLow = 1'b1;
          stateD      = ST_RD0;
        end
      end
      ST_RD0: begin
        ctl.readHigh = 1'b1;
        ctl.holdLow  = 1'b1;
        stateD       = ST_RD1;
      end
      ST_RD1: begin
        ctl.finDesc = 1'b1;
        stateD      = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= ctl.finNull | ctl.finRange | ctl.finDesc;
    end
  end

  assign busy    = (stateQ != ST_IDLE);
  assign memRdEn = ctl.readLow | ctl.readHigh;

endmodule

// File: rtl/segFetchPath.sv
module segFetchPath
  import segfetch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  pathCtrl_t           ctl,
  input  logic [SEL_W-1:0]    selector,
  input  logic [ADDR_W-1:0]   gdtBase,
  input  logic [ADDR_W-1:0]   gdtLimit,
  input  logic [ADDR_W-1:0]   ldtBase,
  input  logic [ADDR_W-1:0]   ldtLimit,
  input  logic [DESC_W-1:0]   memRdData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                isNull,
  output logic                rangeBad,
  output logic                fault,
  output logic [SEL_W-1:0]    faultCode,
  output logic [DESC_W-1:0]   segBase,
  output logic [DESC_W-1:0]   segLimit,
  output logic [DESC_W-1:0]   segFlags
);

  localparam int RAW_LIM_W = 20;
  localparam int PAGE_W    = DESC_W - RAW_LIM_W;

  logic [SEL_W-1:2]  selIdxQ;
  logic [ADDR_W-1:0] tblBaseQ, tblLimitQ;
  logic [DESC_W-1:0] lowWordQ;

  logic [ADDR_W-1:0]    entryOff;
  logic [ADDR_W:0]      entryEnd;
  logic [DESC_W-1:0]    nextBase, nextLimit;
  logic [RAW_LIM_W-1:0] rawLimit;
  logic                 typeBad;

  // the table is picked once, when the request is taken
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdxQ   <= '0;
      tblBaseQ  <= '0;
      tblLimitQ <= '0;
      lowWordQ  <= '0;
    end else begin
      if (ctl.capture) begin
        selIdxQ   <= selector[SEL_W-1:2];
        tblBaseQ  <= selector[2] ? ldtBase : gdtBase;
        tblLimitQ <= selector[2] ? ldtLimit : gdtLimit;
      end
      if (ctl.holdLow) lowWordQ <= memRdData;
    end
  end

  assign entryOff = ADDR_W'({selIdxQ[SEL_W-1:3], 3'b000});
  assign entryEnd = {1'b0, entryOff} + (ADDR_W+1)'(7);
  assign rangeBad = entryEnd > {1'b0, tblLimitQ};
  assign isNull   = (selIdxQ == '0);
  assign memAddr  = tblBaseQ + entryOff + (ctl.readHigh ? ADDR_W'(4) : ADDR_W'(0));

  // descriptor unpacking: memRdData holds the upper word here
  assign nextBase = {memRdData[31:24], memRdData[7:0], lowWordQ[31:16]};
  assign rawLimit = {memRdData[19:16], lowWordQ[15:0]};
  assign nextLimit = memRdData[BIT_GRAN] ? {rawLimit, {PAGE_W{1'b1}}}
                                         : {{PAGE_W{1'b0}}, rawLimit};
  assign typeBad  = !memRdData[BIT_CLASS] ||
                    (memRdData[BIT_EXEC] && !memRdData[BIT_READ]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fault     <= 1'b0;
      faultCode <= '0;
      segBase   <= '0;
      segLimit  <= '0;
      segFlags  <= '0;
    end else begin
      fault <= ctl.finRange | (ctl.finDesc & typeBad);
      if (ctl.finRange || (ctl.finDesc && typeBad))
        faultCode <= {selIdxQ, 2'b00};
      if (ctl.finNull) begin
        segBase  <= '0;
        segLimit <= '0;
        segFlags <= '0;
      end else if (ctl.finDesc && !typeBad) begin
        segBase  <= nextBase;
        segLimit <= nextLimit;
        segFlags <= memRdData;
      end
    end
  end

endmodule

// File: rtl/segDescFetch.sv
module segDescFetch
  import segfetch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [15:0]       selector,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [ADDR_W-1:0] gdtLimit,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [ADDR_W-1:0] ldtLimit,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memRdData,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [15:0]       faultCode,
  output logic [31:0]       segBase,
  output logic [31:0]       segLimit,
  output logic [31:0]       segFlags
);

  pathCtrl_t ctl;
  logic      isNull, rangeBad;

  segFetchCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .isNull   (isNull),
    .rangeBad (rangeBad),
    .ctl      (ctl),
    .busy     (busy),
    .memRdEn  (memRdEn),
    .done     (done)
  );

  segFetchPath #(.ADDR_W(ADDR_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .selector  (selector),
    .gdtBase   (gdtBase),
    .gdtLimit  (gdtLimit),
    .ldtBase   (ldtBase),
    .ldtLimit  (ldtLimit),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .isNull    (isNull),
    .rangeBad  (rangeBad),
    .fault     (fault),
    .faultCode (faultCode),
    .segBase   (segBase),
    .segLimit  (segLimit),
    .segFlags  (segFlags)
  );

endmodule

// File: rtl/segDescFetchChk.sv
module segDescFetchChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [15:0]       selector,
  input logic [ADDR_W-1:0] gdtBase,
  input logic [ADDR_W-1:0] gdtLimit,
  input logic [ADDR_W-1:0] ldtBase,
  input logic [ADDR_W-1:0] ldtLimit,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memRdData,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [15:0]       faultCode,
  input logic [31:0]       segBase,
  input logic [31:0]       segLimit,
  input logic [31:0]       segFlags
);

  assert_read_when_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  assert_accept_sets_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

  assert_second_word_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> (memAddr == $past(memAddr) + ADDR_W'(4)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fault_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done);

  assert_fault_code_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (faultCode[1:0] == 2'b00));

  assert_page_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault && segFlags[23]) |-> (segLimit[11:0] == 12'hFFF));

  assert_null_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault && !segFlags[12]) |-> (segBase == 32'd0 && segLimit == 32'd0 && segFlags == 32'd0));

  assert_valid_class_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault && segFlags[12]) |-> !(segFlags[11] && !segFlags[9]));

endmodule

bind segDescFetch segDescFetchChk #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_segDescFetch.sv
module tb_segDescFetch;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int N_IDX      = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [15:0]       selector = '0;
  logic [ADDR_W-1:0] gdtBase  = 32'h100;
  logic [ADDR_W-1:0] gdtLimit = 32'h3F;
  logic [ADDR_W-1:0] ldtBase  = 32'h200;
  logic [ADDR_W-1:0] ldtLimit = 32'h2B;
  logic              memRdEn;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0]       memRdData = '0;
  logic              busy, done, fault;
  logic [15:0]       faultCode;
  logic [31:0]       segBase, segLimit, segFlags;

  logic [31:0] mem [0:255];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segDescFetch #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .selector(selector),
    .gdtBase(gdtBase), .gdtLimit(gdtLimit), .ldtBase(ldtBase), .ldtLimit(ldtLimit),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .busy(busy), .done(done), .fault(fault), .faultCode(faultCode),
    .segBase(segBase), .segLimit(segLimit), .segFlags(segFlags)
  );

  always_ff @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr[9:2]];
  end

  function automatic logic [31:0] lowWord(int t, int i);
    return {16'(i * 16'h1111 + t * 16'h0F0F), 16'(16'h1234 + i * 16'h0101)};
  endfunction

  // bit 23 granularity, 12 class, 11 executable, 9 readable
  function automatic logic [31:0] highWord(int t, int i);
    logic [31:0] w;
    w = '0;
    w[31:24] = 8'(8'h10 * i + t);
    w[23]    = i[0];
    w[22]    = 1'b1;
    w[19:16] = 4'(i);
    w[15]    = 1'b1;
    w[14:13] = 2'(i);
    w[12]    = (i != 3);
    w[11]    = (i % 4 == 2);
    w[9]     = (i != 6);
    w[7:0]   = 8'(8'h30 + i);
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [15:0] sel, input int holdCycles,
                        input logic [15:0] otherSel, output int lat,
                        output int nRd, output logic [31:0] a0,
                        output logic [31:0] a1);
    int k;
    lat = 0; nRd = 0; a0 = '0; a1 = '0;
    @(negedge clk);
    selector = sel;
    reqValid = 1'b1;
    k = 0;
    while (k < 20) begin
      @(negedge clk);
      k++;
      if (k == 1) check(busy == 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
      if (done) break;
      if (memRdEn) begin
        if (nRd == 0) a0 = memAddr; else a1 = memAddr;
        nRd++;
      end
      if (k <= holdCycles) begin
        selector = otherSel;
        reqValid = 1'b1;
      end else begin
        reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    lat = k;
    if (!done) check(1'b0, "R8 done never seen", 32'(k), 32'd0);
  endtask

  task automatic runCase(input logic [15:0] sel, input int holdCycles,
                         input logic [15:0] otherSel);
    int lat, nRd, idx, t;
    logic [31:0] a0, a1, w0, w1, expBase, expLim, tb, tl, offs;
    logic [19:0] raw;
    logic isNull, rangeFail, typeFail;
    idx = int'(sel[15:3]);
    t   = int'(sel[2]);
    tb  = t ? ldtBase : gdtBase;
    tl  = t ? ldtLimit : gdtLimit;
    offs = {16'd0, sel[15:3], 3'b000};
    isNull    = (sel[15:2] == 14'd0);
    rangeFail = !isNull && (offs + 32'd7 > tl);
    w0 = lowWord(t, idx);
    w1 = highWord(t, idx);
    typeFail = !w1[12] || (w1[11] && !w1[9]);
    raw = {w1[19:16], w0[15:0]};
    expLim  = w1[23] ? {raw, 12'hFFF} : {12'd0, raw};
    expBase = {w1[31:24], w1[7:0], w0[31:16]};

    doLoad(sel, holdCycles, otherSel, lat, nRd, a0, a1);

    if (isNull || rangeFail) begin
      check(lat == 2, "R8 short latency", 32'(lat), 32'd2);
      check(nRd == 0, isNull ? "R5 no read on null" : "R2 no read on range fault",
            32'(nRd), 32'd0);
    end else begin
      check(lat == 4, "R8 fetch latency", 32'(lat), 32'd4);
      check(nRd == 2, "R1 two reads", 32'(nRd), 32'd2);
      check(a0 == tb + offs, "R1 first address", a0, tb + offs);
      check(a1 == tb + offs + 32'd4, "R1 second address", a1, tb + offs + 32'd4);
    end

    if (isNull) begin
      check(fault == 1'b0, "R5 null no fault", 32'(fault), 32'd0);
      check(segBase == 0 && segLimit == 0 && segFlags == 0, "R5 null empty",
            segBase | segLimit | segFlags, 32'd0);
    end else if (rangeFail) begin
      check(fault == 1'b1, "R2 range fault", 32'(fault), 32'd1);
      check(faultCode == {sel[15:2], 2'b00}, "R2 fault code", 32'(faultCode),
            32'({sel[15:2], 2'b00}));
    end else if (typeFail) begin
      check(fault == 1'b1, "R6 type fault", 32'(fault), 32'd1);
      check(faultCode == {sel[15:2], 2'b00}, "R6 fault code", 32'(faultCode),
            32'({sel[15:2], 2'b00}));
    end else begin
      check(fault == 1'b0, "R6 valid no fault", 32'(fault), 32'd0);
      check(segBase == expBase, "R3 base", segBase, expBase);
      check(segLimit == expLim, "R4 limit", segLimit, expLim);
      check(segFlags == w1, "R7 flags", segFlags, w1);
    end

    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", 32'(done), 32'd0);
    check(busy == 1'b0, "R9 idle after done", 32'(busy), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R8 watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 256; w++) mem[w] = 32'hDEAD_0000 | 32'(w);
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N_IDX; i++) begin
        mem[(t ? 8'h80 : 8'h40) + 2 * i]     = lowWord(t, i);
        mem[(t ? 8'h80 : 8'h40) + 2 * i + 1] = highWord(t, i);
      end

    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && fault == 0 && memRdEn == 0, "R9 reset idle",
          {28'd0, busy, done, fault, memRdEn}, 32'd0);
    check(segBase == 0 && segLimit == 0 && segFlags == 0, "R5 reset outputs",
          segBase | segLimit | segFlags, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // sweep every index of both tables, past each table limit
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N_IDX; i++)
        runCase({13'(i), 1'(t), 2'(i)}, 0, 16'd0);

    // null selector with nonzero requested privilege
    runCase(16'h0003, 0, 16'd0);

    // R9: requests held across a busy fetch are ignored
    runCase(16'h0012, 3, 16'h000B);
    check(memRdEn == 1'b0, "R9 ignored request started nothing", 32'(memRdEn), 32'd0);

    // R9: request during a short (range fault) load is ignored as well
    runCase(16'h0058, 1, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule